// File: doc/BRIEF.md
# Serial TDM Input Delay and Fractional-Sample Aligner

This block takes one serial time-division multiplexed input line that shares a frame pulse with the rest of the system. It moves the point where each bit is captured later by a whole number of bit cells, from zero to seven. Within the chosen bit cell it also picks one of four quarter positions for the capture. The captured bits are then packed into channel bytes, most significant bit first, and each byte is handed out with its channel number. This lets a receiver absorb line skew without any change to the upstream timing.

The block runs on one clock that is four times the highest line rate (65.536 MHz for the default parameters). A frame always lasts 8192 clocks, and there are four line rates. The current rate and the packed 5-bit control word are both taken in at a frame pulse. A new setting therefore never cuts into a frame that is already running.

Top module: `tdm_rx_aligner`

## Requirements
- R1: `ctrl_i[4:2]` is the whole-bit delay d and `ctrl_i[1:0]` is the sampling-point code; both are captured together with `mode_i` in the clock cycle where `fp_i` is high.
- R2: The capture instant for bit k of a frame lies d bit cells later than the nominal instant for that bit, for every d from 0 to 7.
- R3: The sampling codes select the quarter point q as follows: 01 gives 1/4, 10 gives 1/2, 00 gives 3/4 and 11 gives 4/4. Bit k is sampled in the clock (k+d)·P + q·P/4 − 1, counted from the frame-pulse clock (clock 0), where P is the number of clocks per bit. After reset the held setting is d=0, code 00, mode 0.
- R4: `mode_i` 0, 1, 2 and 3 select 32, 16, 8 and 4 clocks per bit, that is 2.048, 4.096, 8.192 and 16.384 Mbit/s. A frame is 8192 clocks in every mode.
- R5: In mode 3, codes 01 and 00 act as the 1/2 point. Codes 10 and 11 keep their normal meaning.
- R6: Channel numbers run from 0 up to 31, 63, 127 or 255 in modes 0 to 3.
- R7: The first bit sampled for a channel is placed in bit 7 of `byte_o` and the last in bit 0.
- R8: A delayed sample that falls after the next frame pulse still belongs to the last channel of the frame it was taken for, and that byte is still delivered.
- R9: Changes on `mode_i` or `ctrl_i` between frame pulses have no effect on sampling until the next frame pulse.
- R10: No byte is delivered before the first frame pulse after reset. After that first pulse, or after a pulse that brings a different setting, partly collected bytes are discarded, and the first byte delivered is channel 0 of the new frame.
- R11: `byte_vld_o` is high for exactly one clock, the clock after the sample of a channel's last bit. `byte_ch_o` and `byte_o` are valid in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, four clocks per bit at the top rate |
| rst_n | input | 1 | Synchronous reset, active low |
| fp_i | input | 1 | Frame pulse, high for one clock at frame start |
| sdi_i | input | 1 | Serial TDM data |
| mode_i | input | 2 | Line-rate select, 0 (slowest) to 3 (fastest) |
| ctrl_i | input | 5 | Packed control: bit delay in [4:2], sampling code in [1:0] |
| byte_vld_o | output | 1 | One-clock strobe for a completed channel byte |
| byte_ch_o | output | 8 | Channel number of the delivered byte |
| byte_o | output | 8 | Delivered byte, first received bit in bit 7 |

## Verification
The assertions check four things on every clock. The held setting stays fixed between frame pulses. The held fraction in the top mode is only ever 1/2 or 4/4. Strobes never come two clocks in a row, never appear before lock or right after a restart, and never carry a channel number past the last channel of the mode. Only the scenarios can show that each code and delay lands on the right clock: the bench drives the correct bit only during the selected quarter of the intended cell. The scenarios also show that bytes spilling past a frame pulse arrive intact, that a mid-frame control change waits for the next pulse, and that the top-rate remapping is applied.

// File: rtl/tdm_align_pkg.sv
// Package: shared sampling-code encoding and its decode to quarter points.
// Assumes four clocks per bit at the fastest line rate.
package tdm_align_pkg;

    // Log2 of the clocks per bit at the fastest rate.
    localparam int OVS_LOG = 2;

    // Sampling-point codes, as they appear in ctrl[1:0].
    typedef enum logic [1:0] {
        SP_QTR1 = 2'b01,
        SP_HALF = 2'b10,
        SP_QTR3 = 2'b00,
        SP_FULL = 2'b11
    } samp_code_e;

    // Turns a sampling code into a quarter count 1..4; the top rate keeps only 2 and 4.
    function automatic logic [2:0] code_quarters(input logic [1:0] code, input logic top_rate);
        logic [2:0] q;
        case (samp_code_e'(code))
            SP_QTR1: q = 3'd1;
            SP_HALF: q = 3'd2;
            SP_QTR3: q = 3'd3;
            default: q = 3'd4;
        endcase
        if (top_rate && (q == 3'd1 || q == 3'd3)) begin
            q = 3'd2;
        end
        return q;
    endfunction

endpackage

// File: rtl/tdm_cfg_latch.sv
// Module: holds rate, bit delay and quarter point, loaded only at a frame pulse.
// Provides the setting in force this clock (the new one during the pulse clock),
// a lock flag, and a restart flag for the first pulse or a changed setting.
// Assumes fp_i is a single-clock pulse.
module tdm_cfg_latch
    import tdm_align_pkg::*;
#(
    parameter int NMODES = 4,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [4:0]        ctrl_i,
    output logic [MODE_W-1:0] cur_mode_o,
    output logic [2:0]        cur_delay_o,
    output logic [2:0]        cur_q_o,
    output logic [MODE_W-1:0] held_mode_o,
    output logic              locked_o,
    output logic              active_o,
    output logic              restart_o
);

    localparam logic [MODE_W-1:0] TOP_MODE = MODE_W'(NMODES - 1);

    logic [MODE_W-1:0] new_mode;
    logic [2:0]        new_delay;
    logic [2:0]        new_q;
    logic [MODE_W-1:0] held_mode;
    logic [2:0]        held_delay;
    logic [2:0]        held_q;
    logic              locked;
    logic              changed;

    // Decode the inputs into the setting a frame pulse would load.
    always_comb begin
        new_mode  = (mode_i > TOP_MODE) ? TOP_MODE : mode_i;
        new_delay = ctrl_i[4:2];
        new_q     = code_quarters(ctrl_i[1:0], new_mode == TOP_MODE);
        changed   = (new_mode != held_mode) || (new_delay != held_delay) || (new_q != held_q);
    end

    // Pick the setting in force this clock and flag a restart.
    always_comb begin
        cur_mode_o  = fp_i ? new_mode  : held_mode;
        cur_delay_o = fp_i ? new_delay : held_delay;
        cur_q_o     = fp_i ? new_q     : held_q;
        active_o    = locked || fp_i;
        restart_o   = fp_i && (!locked || changed);
    end

    // Load the held setting and set lock on each frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_mode  <= '0;
            held_delay <= 3'd0;
            held_q     <= code_quarters(2'b00, 1'b0);
            locked     <= 1'b0;
        end else if (fp_i) begin
            held_mode  <= new_mode;
            held_delay <= new_delay;
            held_q     <= new_q;
            locked     <= 1'b1;
        end
    end

    assign held_mode_o = held_mode;
    assign locked_o    = locked;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_i |=> $stable(held_mode) && $stable(held_delay) && $stable(held_q)); // R9

    AST_TOP_RATE_FRACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && held_mode == TOP_MODE) |-> (held_q == 3'd2 || held_q == 3'd4)); // R5

endmodule

// File: rtl/tdm_phase_ctr.sv
// Module: frame phase counter already moved back by the sampling offset.
// During the pulse clock its value is minus the offset (modulo the frame length).
// A value that is a multiple of the bit-cell length marks a sampling clock, and the
// quotient is the bit index. Assumes the frame length is a power of two.
module tdm_phase_ctr
    import tdm_align_pkg::*;
#(
    parameter int LOW_CH  = 32,
    parameter int NMODES  = 4,
    parameter int MODE_W  = 2,
    parameter int FRAME_W = 13,
    parameter int TL_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fp_i,
    input  logic [MODE_W-1:0]  cur_mode_i,
    input  logic [2:0]         cur_delay_i,
    input  logic [2:0]         cur_q_i,
    output logic [FRAME_W-1:0] phase_o,
    output logic [TL_W-1:0]    cell_log_o
);

    localparam int SLOW_LOG = OVS_LOG + NMODES - 1;

    logic [FRAME_W-1:0] phase_q;
    logic [FRAME_W-1:0] offset;
    logic [TL_W-1:0]    qtr_log;

    // Work out the cell size for the rate and the full sampling offset.
    always_comb begin
        cell_log_o = TL_W'(SLOW_LOG) - TL_W'(cur_mode_i);
        qtr_log    = cell_log_o - TL_W'(OVS_LOG);
        offset     = (FRAME_W'(cur_delay_i) << cell_log_o)
                   + (FRAME_W'(cur_q_i) << qtr_log)
                   - FRAME_W'(1);
        phase_o    = fp_i ? (FRAME_W'(0) - offset) : phase_q;
    end

    // Advance the phase by one each clock, wrapping at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_o + FRAME_W'(1);
        end
    end

endmodule

// File: rtl/tdm_bit_pick.sv
// Module: finds the sampling clocks in the phase and splits the bit index
// into a channel number and a position within the byte (0 = first bit).
// Assumes the phase is below the frame length.
module tdm_bit_pick #(
    parameter int FRAME_W = 13,
    parameter int TL_W    = 3,
    parameter int CH_W    = 8
) (
    input  logic               active_i,
    input  logic [FRAME_W-1:0] phase_i,
    input  logic [TL_W-1:0]    cell_log_i,
    output logic               take_o,
    output logic [2:0]         pos_o,
    output logic [CH_W-1:0]    ch_o
);

    localparam int SPARE_W = FRAME_W - CH_W - 3;

    logic [FRAME_W-1:0] cell_mask;
    logic [FRAME_W-1:0] bit_idx;
    logic [SPARE_W-1:0] spare;

    // Decide whether this clock samples, and for which bit.
    always_comb begin
        cell_mask              = (FRAME_W'(1) << cell_log_i) - FRAME_W'(1);
        bit_idx                = phase_i >> cell_log_i;
        {spare, ch_o, pos_o}   = bit_idx;
        take_o = active_i && ((phase_i & cell_mask) == '0) && (spare == '0);
    end

endmodule

// File: rtl/tdm_byte_asm.sv
// Module: shifts in sampled bits, first bit into the top, and sends a byte with
// its channel number when its last bit arrives. A byte is only sent if its first
// bit was sampled since the last restart.
module tdm_byte_asm #(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [2:0]      pos_i,
    input  logic [CH_W-1:0] ch_i,
    input  logic            sdi_i,
    input  logic            restart_i,
    output logic            vld_o,
    output logic [CH_W-1:0] ch_o,
    output logic [7:0]      byte_o
);

    logic [6:0] shreg;
    logic       primed;
    logic       primed_eff;

    // Drop the collected prefix whenever a restart happens.
    always_comb begin
        primed_eff = restart_i ? 1'b0 : primed;
    end

    // Collect bits and send full bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            primed <= 1'b0;
            vld_o  <= 1'b0;
            ch_o   <= '0;
            byte_o <= '0;
        end else begin
            vld_o  <= 1'b0;
            primed <= primed_eff;
            if (take_i) begin
                shreg <= {shreg[5:0], sdi_i};
                if (pos_i == 3'd0) begin
                    primed <= 1'b1;
                end
                if (pos_i == 3'd7 && primed_eff) begin
                    vld_o  <= 1'b1;
                    ch_o   <= ch_i;
                    byte_o <= {shreg, sdi_i};
                end
            end
        end
    end

    AST_RESTART_DROPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !vld_o); // R10

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o); // R11

endmodule

// File: rtl/tdm_rx_aligner.sv
// Module: top level of the serial TDM input aligner. The setting is captured at
// the frame pulse, a phase counter is moved back by the delay plus the quarter
// point, and the bits sampled on that phase are packed into channel bytes.
// Assumes fp_i arrives once per 8192 clocks (default parameters) and that
// clk runs at four times the fastest line rate.
module tdm_rx_aligner #(
    parameter  int LOW_CH = 32,
    parameter  int NMODES = 4,
    localparam int MODE_W = (NMODES > 1) ? $clog2(NMODES) : 1,
    localparam int CH_W   = $clog2(LOW_CH) + NMODES - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_i,
    input  logic              sdi_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [4:0]        ctrl_i,
    output logic              byte_vld_o,
    output logic [CH_W-1:0]   byte_ch_o,
    output logic [7:0]        byte_o
);

    localparam int SLOW_LOG = tdm_align_pkg::OVS_LOG + NMODES - 1;
    localparam int FRAME_W  = CH_W + 3 + tdm_align_pkg::OVS_LOG;
    localparam int TL_W     = $clog2(SLOW_LOG + 1);

    logic [MODE_W-1:0]  cur_mode;
    logic [2:0]         cur_delay;
    logic [2:0]         cur_q;
    logic [MODE_W-1:0]  held_mode;
    logic               locked;
    logic               active;
    logic               restart;
    logic [FRAME_W-1:0] phase;
    logic [TL_W-1:0]    cell_log;
    logic               take;
    logic [2:0]         pos;
    logic [CH_W-1:0]    ch;

    tdm_cfg_latch #(
        .NMODES (NMODES),
        .MODE_W (MODE_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .fp_i        (fp_i),
        .mode_i      (mode_i),
        .ctrl_i      (ctrl_i),
        .cur_mode_o  (cur_mode),
        .cur_delay_o (cur_delay),
        .cur_q_o     (cur_q),
        .held_mode_o (held_mode),
        .locked_o    (locked),
        .active_o    (active),
        .restart_o   (restart)
    );

    tdm_phase_ctr #(
        .LOW_CH  (LOW_CH),
        .NMODES  (NMODES),
        .MODE_W  (MODE_W),
        .FRAME_W (FRAME_W),
        .TL_W    (TL_W)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .fp_i        (fp_i),
        .cur_mode_i  (cur_mode),
        .cur_delay_i (cur_delay),
        .cur_q_i     (cur_q),
        .phase_o     (phase),
        .cell_log_o  (cell_log)
    );

    tdm_bit_pick #(
        .FRAME_W (FRAME_W),
        .TL_W    (TL_W),
        .CH_W    (CH_W)
    ) u_pick (
        .active_i   (active),
        .phase_i    (phase),
        .cell_log_i (cell_log),
        .take_o     (take),
        .pos_o      (pos),
        .ch_o       (ch)
    );

    tdm_byte_asm #(
        .CH_W (CH_W)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .pos_i     (pos),
        .ch_i      (ch),
        .sdi_i     (sdi_i),
        .restart_i (restart),
        .vld_o     (byte_vld_o),
        .ch_o      (byte_ch_o),
        .byte_o    (byte_o)
    );

    AST_NO_BYTE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> locked); // R10

    AST_CHANNEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> (int'(byte_ch_o) <= ((LOW_CH << held_mode) - 1))); // R6

endmodule

// File: tb/tdm_rx_aligner_test.sv
// Bench: a behavioural transmitter drives each bit correctly only during its
// intended quarter of the delayed cell. A queue-based model predicts every byte
// strobe by clock number, and the two are compared on every clock.
module tdm_rx_aligner_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int  FRAME = 8192;
    localparam int  FP0   = 200;
    localparam int  NSCEN = 7;
    localparam longint END_CYC = FP0 + 2 * NSCEN * FRAME + FRAME;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp_i = 1'b0;
    logic       sdi_i = 1'b0;
    logic [1:0] mode_i;
    logic [4:0] ctrl_i;
    logic       byte_vld_o;
    logic [7:0] byte_ch_o;
    logic [7:0] byte_o;

    always #2 clk = ~clk;

    tdm_rx_aligner uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fp_i       (fp_i),
        .sdi_i      (sdi_i),
        .mode_i     (mode_i),
        .ctrl_i     (ctrl_i),
        .byte_vld_o (byte_vld_o),
        .byte_ch_o  (byte_ch_o),
        .byte_o     (byte_o)
    );

    typedef struct {
        longint cyc;
        int     ch;
        int     data;
    } exp_t;

    exp_t   expq[$];
    int     n_checks = 0;
    int     n_fail = 0;
    longint cyc = 0;
    bit     done = 1'b0;
    bit     s_active = 1'b0;
    int     s_mode, s_d, s_q, in_sc;
    longint s_fp0;
    string  tag = "R10";

    int    sc_mode [NSCEN] = '{0, 1, 2, 3, 3, 3, 0};
    int    sc_ctrl [NSCEN] = '{5'b01110, 5'b00001, 5'b11111, 5'b10101, 5'b01011, 5'b11000, 5'b00000};
    string sc_tag  [NSCEN] = '{"R1 R2 R3 R7 R8 R9 R11", "R3 R4 R6 R9 R10", "R2 R3 R8 R9",
                               "R5 R6 R9", "R3 R4 R9", "R5 R9", "R3 R6 R10 R11"};

    function automatic longint fdiv(longint a, longint b);
        return (a >= 0) ? a / b : -((-a + b - 1) / b);
    endfunction

    function automatic longint fmod(longint a, longint b);
        return a - fdiv(a, b) * b;
    endfunction

    function automatic int byteval(longint f, longint c);
        return int'(fmod(f * 37 + c * 11 + 5, 256));
    endfunction

    // Quarter point from the code list in the requirements, with the top-rate rule.
    function automatic int eff_q(int mode, int code);
        int q;
        case (code)
            1: q = 1;
            2: q = 2;
            0: q = 3;
            default: q = 4;
        endcase
        if (mode == 3 && (q == 1 || q == 3)) q = 2;
        return q;
    endfunction

    // Serial bit for the current clock under the session setting.
    function automatic logic tx_bit();
        longint tpb, u, j, r, nb, f, jj;
        int c, p, qtr, b;
        if (!s_active) return 1'b0;
        tpb = 32 >> s_mode;
        nb  = 8 * (32 << s_mode);
        u   = cyc - s_fp0 - s_d * tpb;
        j   = fdiv(u, tpb);
        r   = fmod(u, tpb);
        qtr = int'(r / (tpb / 4));
        f   = fdiv(j, nb);
        jj  = fmod(j, nb);
        c   = int'(jj / 8);
        p   = int'(jj % 8);
        b   = (byteval(f, c) >> (7 - p)) & 1;
        return logic'(b) ^ (qtr != s_q - 1);
    endfunction

    task automatic check_outputs();
        bit exp_now;
        while (expq.size() > 0 && expq[0].cyc < cyc) begin
            n_checks++;
            n_fail++;
            $display("FAIL [%s] cycle %0d: strobe missing, actual vld=%0b expected ch=%0d byte=%02h",
                     tag, expq[0].cyc, byte_vld_o, expq[0].ch, expq[0].data);
            void'(expq.pop_front());
        end
        exp_now = (expq.size() > 0) && (expq[0].cyc == cyc);
        if (byte_vld_o || exp_now) begin
            n_checks++;
            if (!exp_now) begin
                n_fail++;
                $display("FAIL [%s] cycle %0d: actual vld=1 ch=%0d byte=%02h, expected vld=0",
                         tag, cyc, byte_ch_o, byte_o);
            end else if (!byte_vld_o || int'(byte_ch_o) != expq[0].ch || int'(byte_o) != expq[0].data) begin
                n_fail++;
                $display("FAIL [%s] cycle %0d: actual vld=%0b ch=%0d byte=%02h, expected vld=1 ch=%0d byte=%02h",
                         tag, cyc, byte_vld_o, byte_ch_o, byte_o, expq[0].ch, expq[0].data);
            end
            if (exp_now) void'(expq.pop_front());
        end
    endtask

    // At a frame pulse: start a new session if the setting differs, then predict this frame.
    task automatic model_frame();
        int nm, nd, nq, tpb, nch;
        longint f;
        nm = int'(mode_i);
        nd = int'(ctrl_i[4:2]);
        nq = eff_q(nm, int'(ctrl_i[1:0]));
        if (!s_active || nm != s_mode || nd != s_d || nq != s_q) begin
            while (expq.size() > 0 && expq[$].cyc > cyc) void'(expq.pop_back());
            s_active = 1'b1;
            s_mode = nm;
            s_d = nd;
            s_q = nq;
            s_fp0 = cyc;
            tag = sc_tag[in_sc];
        end
        tpb = 32 >> s_mode;
        nch = 32 << s_mode;
        f = (cyc - s_fp0) / FRAME;
        for (int c = 0; c < nch; c++) begin
            exp_t e;
            e.cyc  = cyc + longint'((c * 8 + 7 + s_d) * tpb + s_q * (tpb / 4) - 1 + 1);
            e.ch   = c;
            e.data = byteval(f, c);
            expq.push_back(e);
        end
    endtask

    initial begin
        in_sc  = 0;
        mode_i = 2'(sc_mode[0]);
        ctrl_i = 5'(sc_ctrl[0]);
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (cyc == 5) begin
                n_checks++;
                if (byte_vld_o !== 1'b0 || byte_ch_o !== 8'd0 || byte_o !== 8'd0) begin
                    n_fail++;
                    $display("FAIL [R10] reset state: actual vld=%0b ch=%0d byte=%02h, expected 0 0 00",
                             byte_vld_o, byte_ch_o, byte_o);
                end
            end
            if (cyc == 8) rst_n = 1'b1;
            check_outputs();
            if (cyc > FP0 && (cyc - FP0) % FRAME == FRAME / 2
                && ((cyc - FP0) / FRAME) % 2 == 1 && in_sc + 1 < NSCEN) begin
                in_sc++;
                mode_i = 2'(sc_mode[in_sc]);
                ctrl_i = 5'(sc_ctrl[in_sc]);
            end
            fp_i = (cyc >= FP0) && ((cyc - FP0) % FRAME == 0);
            if (fp_i) model_frame();
            sdi_i = tx_bit();
            if (cyc >= END_CYC) done = 1'b1;
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL [R11] watchdog expired at cycle %0d, expected end by %0d", cyc, END_CYC);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule